// File: doc/BRIEF.md
# Oversampled PS/2 Keyboard Receiver

This block takes the clock and data wires of a PS/2 keyboard as plain inputs and recovers the keyboard's serial frames entirely in the fast system-clock domain. The keyboard clock is never used to clock a flop. It passes through a synchroniser and a falling-edge detector. After each detected falling edge the receiver waits a fixed number of system cycles before it samples the synchronised data line. The wait gives the data wire time to settle when it moves close to the clock edge.

A frame holds eleven bits: a start bit that is 0, eight data bits with the least-significant bit first, an odd-parity bit and a stop bit that is 1. A frame that passes every check places its byte in a code register on a small 8-bit read bus and raises an interrupt request. The request stays high until the CPU reads the code register. A second bus address returns the pending flag. An activity output is high while a frame is in progress. A watchdog counter brings a stalled frame back to the idle position so that the receiver can pick up the next frame.

Top module: `ps2_rx_top`

## Requirements
- R1: After reset, irq and frame_active are 0, address 0 reads 8'h00 and address 1 reads 8'h00.
- R2: A frame with start bit 0, eight data bits sent least-significant bit first, an odd-parity bit (the data bits and the parity bit together hold an odd number of ones) and stop bit 1 is accepted. A read at address 0 then returns its data byte.
- R3: The data line is sampled SETTLE_CYCLES (default 8) system cycles after a synchronised falling edge of the keyboard clock. A data value that changes two cycles after the falling edge is captured at its new value.
- R4: A falling edge on which the data line is 1 while the receiver is idle does not start a frame. frame_active stays 0 and irq stays 0.
- R5: frame_active goes to 1 when a valid start bit is taken and returns to 0 once the stop-bit position has been sampled.
- R6: irq goes to 1 when an accepted frame completes.
- R7: A read at address 0 clears irq. A read at address 1 leaves irq unchanged.
- R8: A read at address 1 returns the pending flag in bit 0 and zeros in bits 7:1.
- R9: A frame with wrong parity or with a stop bit of 0 is discarded. irq is not raised and address 0 keeps the previous code.
- R10: If no falling edge arrives for TIMEOUT_CYCLES system cycles while a frame is in progress, the receiver returns to idle and frame_active drops. A complete frame sent afterwards is received correctly.
- R11: An accepted frame that arrives while a code is still pending replaces the code, and irq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_clk_i | input | 1 | Keyboard clock wire, asynchronous, idles high |
| kb_dat_i | input | 1 | Keyboard data wire, asynchronous, idles high |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 1 | Register select: 0 selects the code, 1 selects the status |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request: a new code is pending |
| frame_active | output | 1 | High while a frame is being received |

## Verification
The hardest case to reach is a data wire that changes just after the keyboard clock falls. Only the settle delay makes the receiver take the new value. The bench therefore drives every bit with its data change two system cycles after the falling edge, so a receiver that sampled at once would take each previous bit instead. The stalled-frame recovery needs a partial frame followed by silence. The bench lowers TIMEOUT_CYCLES and runs the keyboard clock at a scaled-up rate so that both fit in a short run.

// File: rtl/ps2_rx_pkg.sv
// Package: constants shared by the PS/2 receiver modules.
// Assumes an 11-bit frame with start, 8 data, parity and stop bits.
package ps2_rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [IDX_W-1:0] IDX_IDLE   = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_LAST_D = IDX_W'(DATA_BITS);
    localparam logic [IDX_W-1:0] IDX_PAR    = IDX_W'(DATA_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_STOP   = IDX_W'(DATA_BITS + 2);

    localparam logic ADDR_CODE   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    // True when data plus the parity bit hold an odd number of ones
    function automatic logic odd_ok(input logic [DATA_BITS-1:0] d, input logic p);
        return ^{d, p};
    endfunction
endpackage

// File: rtl/ps2_sync_edge.sv
// Synchroniser and falling-edge detector for the keyboard wires.
// Assumes both wires idle high; reset loads every stage with 1.
module ps2_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_dat_i,
    output logic dat_s,
    output logic fall
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_prev;

    // Shift both wires through the synchroniser chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '1;
            dat_pipe <= '1;
            clk_prev <= 1'b1;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-2:0], kb_clk_i};
            dat_pipe <= {dat_pipe[STAGES-2:0], kb_dat_i};
            clk_prev <= clk_pipe[STAGES-1];
        end
    end

    // Edge pulse and synchronised data
    assign fall  = clk_prev & ~clk_pipe[STAGES-1];
    assign dat_s = dat_pipe[STAGES-1];

    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/ps2_frame_rx.sv
// Frame receiver: waits SETTLE_CYCLES after each falling edge, then
// samples a bit, checks framing and parity, and pulses frame_ok.
// Assumes fall is a one-cycle pulse and dat_s is already synchronised.
module ps2_frame_rx
    import ps2_rx_pkg::*;
#(
    parameter int SETTLE_CYCLES  = 8,
    parameter int TIMEOUT_CYCLES = 250000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall,
    input  logic                 dat_s,
    output logic                 frame_ok,
    output logic [DATA_BITS-1:0] frame_byte,
    output logic                 active
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES - 1);
    localparam logic [TW-1:0] TIME_LIM    = TW'(TIMEOUT_CYCLES - 1);

    logic [SW-1:0]        settle_cnt;
    logic                 waiting;
    logic                 sample_now;
    logic [IDX_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_q;
    logic [TW-1:0]        tcnt;
    logic                 timeout_hit;

    assign sample_now  = waiting && (settle_cnt == '0);
    assign timeout_hit = (bit_idx != IDX_IDLE) && !fall && !sample_now && (tcnt == TIME_LIM);

    // Settle delay between a falling edge and the data sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting    <= 1'b0;
            settle_cnt <= '0;
        end else if (fall) begin
            waiting    <= 1'b1;
            settle_cnt <= SETTLE_LOAD;
        end else if (waiting) begin
            if (settle_cnt == '0) waiting <= 1'b0;
            else                  settle_cnt <= settle_cnt - 1'b1;
        end
    end

    // Bit position, shift register and frame validation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= IDX_IDLE;
            shreg    <= '0;
            par_q    <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            if (sample_now) begin
                if (bit_idx == IDX_IDLE) begin
                    if (!dat_s) bit_idx <= bit_idx + 1'b1;
                end else if (bit_idx <= IDX_LAST_D) begin
                    shreg   <= {dat_s, shreg[DATA_BITS-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end else if (bit_idx == IDX_PAR) begin
                    par_q   <= dat_s;
                    bit_idx <= bit_idx + 1'b1;
                end else begin
                    bit_idx  <= IDX_IDLE;
                    frame_ok <= dat_s && odd_ok(shreg, par_q);
                end
            end else if (timeout_hit) begin
                bit_idx <= IDX_IDLE;
            end
        end
    end

    // Watchdog on the gap between edges inside a frame
    always_ff @(posedge clk) begin
        if (!rst_n) tcnt <= '0;
        else if (bit_idx == IDX_IDLE || fall || tcnt == TIME_LIM) tcnt <= '0;
        else tcnt <= tcnt + 1'b1;
    end

    assign frame_byte = shreg;
    assign active     = (bit_idx != IDX_IDLE);

    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && bit_idx == IDX_STOP) |=> !active);
    assert_stop_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> ($past(dat_s) && $past(bit_idx) == IDX_STOP));
    assert_bad_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && bit_idx == IDX_IDLE && dat_s) |=> !active);
    assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> !active);
endmodule

// File: rtl/ps2_bus_regs.sv
// Code register, pending flag and read mux for the 8-bit bus.
// Assumes frame_ok is a one-cycle pulse; a new frame wins over a clearing read.
module ps2_bus_regs
    import ps2_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_ok,
    input  logic [DATA_BITS-1:0] frame_byte,
    input  logic                 bus_rd,
    input  logic                 bus_addr,
    output logic [7:0]           bus_rdata,
    output logic                 irq
);
    logic [DATA_BITS-1:0] code_q;
    logic                 pend_q;
    logic                 rd_code;

    assign rd_code = bus_rd && (bus_addr == ADDR_CODE);

    // Capture codes and track the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            pend_q <= 1'b0;
        end else if (frame_ok) begin
            code_q <= frame_byte;
            pend_q <= 1'b1;
        end else if (rd_code) begin
            pend_q <= 1'b0;
        end
    end

    // Read data selection
    always_comb begin
        if (bus_addr == ADDR_STATUS) bus_rdata = {7'b0, pend_q};
        else                         bus_rdata = code_q;
    end

    assign irq = pend_q;

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> irq);
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code && !frame_ok) |=> !irq);
    assert_status_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STATUS && irq) |=> irq);
endmodule

// File: rtl/ps2_rx_top.sv
// Top level of the PS/2 receiver: synchroniser, frame receiver, bus registers.
// Assumes a system clock far faster than the keyboard clock.
module ps2_rx_top #(
    parameter int SETTLE_CYCLES  = 8,
    parameter int TIMEOUT_CYCLES = 250000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    input  logic       bus_rd,
    input  logic       bus_addr,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       frame_active
);
    logic       dat_s;
    logic       fall;
    logic       frame_ok;
    logic [7:0] frame_byte;

    ps2_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
        .dat_s(dat_s), .fall(fall)
    );

    ps2_frame_rx #(.SETTLE_CYCLES(SETTLE_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_rx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .dat_s(dat_s),
        .frame_ok(frame_ok), .frame_byte(frame_byte), .active(frame_active)
    );

    ps2_bus_regs u_regs (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_byte(frame_byte),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq)
    );
endmodule

// File: tb/ps2_rx_top_tb.sv
module ps2_rx_top_tb;
    localparam int HALF    = 40;
    localparam int TIMEOUT = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_dat = 1'b1;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       frame_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] last_code = 8'h00;
    logic [7:0] rv;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ps2_rx_top #(.SETTLE_CYCLES(8), .TIMEOUT_CYCLES(TIMEOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .irq(irq), .frame_active(frame_active)
    );

    // Stimulus table: data, flip parity, stop value, expect accept
    localparam logic [10:0] VEC [6] = '{
        {8'h1C, 1'b0, 1'b1, 1'b1},
        {8'hF0, 1'b0, 1'b1, 1'b1},
        {8'h00, 1'b0, 1'b1, 1'b1},
        {8'h5A, 1'b1, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b1, 1'b1},
        {8'h33, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One keyboard bit; data moves two cycles after the falling edge (R3)
    task automatic send_bit(input logic v);
        kb_clk = 1'b0;
        wait_cyc(2);
        kb_dat = v;
        wait_cyc(HALF - 2);
        kb_clk = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_v, input logic chk_busy);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            send_bit(d[i]);
            if (chk_busy && i == 3) check("R5 busy mid-frame", {7'b0, frame_active}, 8'h01);
        end
        send_bit((~^d) ^ flip);
        send_bit(stop_v);
        kb_dat = 1'b1;
        wait_cyc(20);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        bus_addr = 1'b0;
    endtask

    initial begin
        wait (cyc > 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 active", {7'b0, frame_active}, 8'h00);
        bus_read(1'b0, rv); check("R1 code", rv, 8'h00);
        bus_read(1'b1, rv); check("R1 status", rv, 8'h00);

        // Table walk: R2 R3 R6 R7 R9
        for (int k = 0; k < 6; k++) begin
            send_frame(VEC[k][10:3], VEC[k][2], VEC[k][1], k == 0);
            check("R5 busy after stop", {7'b0, frame_active}, 8'h00);
            check(VEC[k][0] ? "R6 irq raised" : "R9 no irq", {7'b0, irq}, {7'b0, VEC[k][0]});
            if (VEC[k][0]) last_code = VEC[k][10:3];
            bus_read(1'b0, rv);
            check(VEC[k][0] ? "R2 R3 code" : "R9 code kept", rv, last_code);
            check("R7 irq cleared", {7'b0, irq}, 8'h00);
        end

        // R8 and R7: status read shows pending and does not clear it
        send_frame(8'hA5, 1'b0, 1'b1, 1'b0);
        bus_read(1'b1, rv); check("R8 status pending", rv, 8'h01);
        check("R7 status keeps irq", {7'b0, irq}, 8'h01);

        // R11 overwrite while pending
        send_frame(8'h3C, 1'b0, 1'b1, 1'b0);
        check("R11 irq held", {7'b0, irq}, 8'h01);
        bus_read(1'b0, rv); check("R11 newest code", rv, 8'h3C);
        bus_read(1'b1, rv); check("R8 status clear", rv, 8'h00);

        // R4 a falling edge with data high starts nothing
        send_bit(1'b1);
        wait_cyc(10);
        check("R4 no frame", {7'b0, frame_active}, 8'h00);
        check("R4 no irq", {7'b0, irq}, 8'h00);

        // R10 stalled frame then recovery
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        check("R10 active before stall", {7'b0, frame_active}, 8'h01);
        kb_dat = 1'b1;
        wait_cyc(TIMEOUT + 50);
        check("R10 idle after stall", {7'b0, frame_active}, 8'h00);
        send_frame(8'h69, 1'b0, 1'b1, 1'b0);
        check("R10 irq after recovery", {7'b0, irq}, 8'h01);
        bus_read(1'b0, rv); check("R10 code after recovery", rv, 8'h69);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule